// File: doc/BRIEF.md
# Sigma-Delta Bitstream Decimator

This block is the digital half of a first-order sigma-delta converter. It is built around a differential input pair that serves as the comparator and an external resistor-capacitor network that serves as the integrator. For each channel, the comparator level passes through two synchroniser flops into a quantiser flop. The quantiser bit leaves the chip as the feedback drive for the RC node, which closes the analog loop. Because the loop holds the comparator input near half the supply, the density of ones in the quantiser stream follows the analog input level.

Each channel counts the ones in its quantiser stream over a shared window of 2^N clocks. This is integrate-and-dump decimation. When a window ends, every channel's count is loaded into the output word and a one-cycle strobe is raised. The counts are then cleared, and the next window starts on the following clock with no gap. A window made up entirely of ones clamps to the largest N-bit code. A free-running square wave with an exact 50% duty cycle is also produced. Filtered externally, it gives the half-supply comparator reference, and all channels share it.

Top module: `dsm_decim`

## Requirements
- R1: For each channel c, fb_o[c] equals the cmp_i[c] value sampled at the rising edge three clocks earlier: two synchroniser stages, then the quantiser flop.
- R2: valid_o is high for exactly one cycle at a time. Its first pulse follows the 2^N-th rising edge after reset release, and later pulses repeat every 2^N clocks with no gap.
- R3: At a valid_o pulse, data_o[c*N +: N] holds the number of cycles in which fb_o[c] was 1 during the window just completed. The window is the fb_o values present at the 2^N rising edges up to and including the edge that raised valid_o.
- R4: A window in which fb_o[c] is 1 at every edge gives code 2^N-1. The count clamps instead of wrapping to 0.
- R5: The sample at the last edge of a window counts toward that window only. The count for the next window starts from zero at the following edge.
- R6: data_o changes only in the cycle in which valid_o is high, and holds its value between pulses.
- R7: ref_o toggles every REF_DIV clocks, so its high and low phases each last exactly REF_DIV clocks. It is independent of the channels.
- R8: While rst_ni is low, fb_o, data_o, valid_o and ref_o are all 0.
- R9: Channels are independent. The code of one channel depends only on its own cmp_i bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_i | input | NUM_CH | Raw comparator levels, one per channel |
| fb_o | output | NUM_CH | Quantiser bits driven to the RC feedback nodes |
| ref_o | output | 1 | 50% duty square wave for the shared reference |
| data_o | output | NUM_CH*RES_W | Window codes, channel c at bits [c*RES_W +: RES_W] |
| valid_o | output | 1 | One-cycle strobe marking a new set of codes |

## Verification
The window dump and an incoming sample coincide on the last edge of every window. That edge must both finish the old count, adding a possible final one, and restart the count at zero. The bench drives channels held at all ones, alternating, one-in-four and pseudo-random levels, so the closing sample is often 1. A scoreboard sums the fb_o values it sees for each window and compares them with the code presented at the strobe. On an all-ones channel, the same edge also meets the clamp to 2^N-1, which is judged against a fixed expected code once a window lies fully inside a stable pattern.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

  typedef enum logic {
    REF_LO = 1'b0,
    REF_HI = 1'b1
  } ref_lvl_e;

  function automatic ref_lvl_e ref_flip(ref_lvl_e lvl);
    return (lvl == REF_LO) ? REF_HI : REF_LO;
  endfunction

endpackage

// File: rtl/dsm_sync_quant.sv
module dsm_sync_quant (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_i,
  output logic fb_o
);

  logic meta_q;
  logic sync_q;
  logic fb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      fb_q   <= 1'b0;
    end else begin
      meta_q <= cmp_i;
      sync_q <= meta_q;
      fb_q   <= sync_q;  // quantiser: drives RC and the counter
    end
  end

  assign fb_o = fb_q;

endmodule

// File: rtl/dsm_win_ctr.sv
module dsm_win_ctr #(
  parameter int RES_W = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic last_o
);

  logic [RES_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= pos_q + 1'b1;
  end

  assign last_o = &pos_q;

endmodule

// File: rtl/dsm_int_dump.sv
module dsm_int_dump #(
  parameter int RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic             last_i,
  output logic [RES_W-1:0] code_o
);

  localparam logic [RES_W-1:0] CODE_MAX = '1;

  logic [RES_W-1:0] acc_q;
  logic [RES_W-1:0] code_q;
  logic [RES_W:0]   sum;
  logic [RES_W-1:0] sum_sat;

  assign sum     = {1'b0, acc_q} + {{RES_W{1'b0}}, sample_i};
  assign sum_sat = sum[RES_W] ? CODE_MAX : sum[RES_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      code_q <= '0;
    end else if (last_i) begin
      code_q <= sum_sat;  // closing sample belongs to this window
      acc_q  <= '0;
    end else begin
      acc_q  <= sum_sat;
    end
  end

  assign code_o = code_q;

endmodule

// File: rtl/dsm_ref_div.sv
module dsm_ref_div
  import dsm_pkg::*;
#(
  parameter int REF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ref_o
);

  localparam int CW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam logic [CW-1:0] TERM = CW'(REF_DIV - 1);

  logic [CW-1:0] cnt_q;
  ref_lvl_e      lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= REF_LO;
    end else if (cnt_q == TERM) begin
      cnt_q <= '0;
      lvl_q <= ref_flip(lvl_q);
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ref_o = (lvl_q == REF_HI);

endmodule

// File: rtl/dsm_decim.sv
module dsm_decim #(
  parameter int NUM_CH  = 8,
  parameter int RES_W   = 10,
  parameter int REF_DIV = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH-1:0]       cmp_i,
  output logic [NUM_CH-1:0]       fb_o,
  output logic                    ref_o,
  output logic [NUM_CH*RES_W-1:0] data_o,
  output logic                    valid_o
);

  logic win_last;
  logic valid_q;

  dsm_win_ctr #(.RES_W(RES_W)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .last_o (win_last)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic fb;

    dsm_sync_quant u_quant (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cmp_i  (cmp_i[c]),
      .fb_o   (fb)
    );

    dsm_int_dump #(.RES_W(RES_W)) u_acc (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sample_i (fb),
      .last_i   (win_last),
      .code_o   (data_o[c*RES_W +: RES_W])
    );

    assign fb_o[c] = fb;
  end

  dsm_ref_div #(.REF_DIV(REF_DIV)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ref_o  (ref_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= win_last;
  end

  assign valid_o = valid_q;

endmodule

// File: rtl/dsm_decim_chk.sv
module dsm_decim_chk #(
  parameter int NUM_CH  = 8,
  parameter int RES_W   = 10,
  parameter int REF_DIV = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [NUM_CH-1:0]       cmp_i,
  input logic [NUM_CH-1:0]       fb_o,
  input logic                    ref_o,
  input logic [NUM_CH*RES_W-1:0] data_o,
  input logic                    valid_o
);

  localparam logic [RES_W:0] WIN = (RES_W+1)'(1) << RES_W;
  localparam int RCW = $clog2(REF_DIV + 2);
  localparam logic [RCW-1:0] HALF = RCW'(REF_DIV);

  logic [1:0]     age_q;
  logic [RES_W:0] vgap_q;
  logic [RCW-1:0] rrun_q;
  logic           ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q  <= '0;
      vgap_q <= '0;
      rrun_q <= '0;
      ref_q  <= 1'b0;
    end else begin
      if (age_q != 2'd3) age_q <= age_q + 1'b1;
      vgap_q <= valid_o ? (RES_W+1)'(1) : vgap_q + 1'b1;
      rrun_q <= (ref_o != ref_q) ? RCW'(1) : rrun_q + 1'b1;
      ref_q  <= ref_o;
    end
  end

  AST_FB_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (fb_o == $past(cmp_i, 3))); // R1

  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R2

  AST_VALID_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (vgap_q == WIN)); // R2

  AST_VALID_NO_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (vgap_q < WIN)); // R2

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o)); // R6

  AST_REF_HALF_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_o != ref_q) |-> (rrun_q == HALF)); // R7

  AST_REF_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_o == ref_q) |-> (rrun_q < HALF)); // R7

endmodule

bind dsm_decim dsm_decim_chk #(
  .NUM_CH  (NUM_CH),
  .RES_W   (RES_W),
  .REF_DIV (REF_DIV)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cmp_i   (cmp_i),
  .fb_o    (fb_o),
  .ref_o   (ref_o),
  .data_o  (data_o),
  .valid_o (valid_o)
);

// File: tb/tb_dsm_decim.sv
module tb_dsm_decim;

  localparam int NCH = 4;
  localparam int RW  = 4;
  localparam int RD  = 3;
  localparam int WIN = 1 << RW;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b1;
  logic [NCH-1:0]    cmp_i = '0;
  logic [NCH-1:0]    fb_o;
  logic              ref_o;
  logic [NCH*RW-1:0] data_o;
  logic              valid_o;

  dsm_decim #(.NUM_CH(NCH), .RES_W(RW), .REF_DIV(RD)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmp_i(cmp_i), .fb_o(fb_o),
    .ref_o(ref_o), .data_o(data_o), .valid_o(valid_o)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int mode = 0;
  int win_in_mode = 0;
  int samp_cnt = 0;
  int sums[NCH];
  int ref_run = 0;
  logic ref_prev = 1'b0;
  logic [NCH-1:0] hist[3];
  logic [NCH*RW-1:0] exp_q[$];
  bit exp_due = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit pat(int m, int ch, int t, logic [15:0] r);
    case (m)
      0: case (ch) 0: return 1'b1; 1: return 1'b0; 2: return t[0]; default: return (t % 4) == 0; endcase
      1: case (ch) 0: return 1'b0; 1: return 1'b1; 2: return (t % 4) == 0; default: return (t % 4) != 0; endcase
      default: return r[ch*3];
    endcase
  endfunction

  function automatic int const_code(int m, int ch);
    int t0[NCH] = '{WIN-1, 0, WIN/2, WIN/4};
    int t1[NCH] = '{0, WIN-1, WIN/4, 3*WIN/4};
    return (m == 0) ? t0[ch] : t1[ch];
  endfunction

  // one sampling point: monitor, scoreboard push, then drive
  task automatic cycle_body();
    logic [NCH*RW-1:0] word;
    check(valid_o == exp_due, "R2 valid timing", int'(valid_o), int'(exp_due));
    if (valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 strobe with no window", 1, 0);
      end else begin
        word = exp_q.pop_front();
        for (int c = 0; c < NCH; c++)
          check(data_o[c*RW +: RW] == word[c*RW +: RW], "R3 R5 R9 window count",
                int'(data_o[c*RW +: RW]), int'(word[c*RW +: RW]));
      end
      if (mode < 2 && win_in_mode >= 2)
        for (int c = 0; c < NCH; c++)
          check(int'(data_o[c*RW +: RW]) == const_code(mode, c),
                (const_code(mode, c) == WIN-1) ? "R4 saturated code" : "R3 density code",
                int'(data_o[c*RW +: RW]), const_code(mode, c));
      win_in_mode++;
    end
    exp_due = 0;
    check(fb_o == hist[2], "R1 feedback delay", int'(fb_o), int'(hist[2]));
    for (int c = 0; c < NCH; c++) sums[c] += int'(fb_o[c]);
    samp_cnt++;
    if (samp_cnt == WIN) begin
      for (int c = 0; c < NCH; c++)
        word[c*RW +: RW] = RW'((sums[c] > WIN-1) ? WIN-1 : sums[c]);
      exp_q.push_back(word);
      exp_due = 1;
      samp_cnt = 0;
      for (int c = 0; c < NCH; c++) sums[c] = 0;
    end
    if (ref_o == ref_prev) ref_run++;
    else begin
      check(ref_run == RD, "R7 reference phase length", ref_run, RD);
      ref_run = 1;
    end
    ref_prev = ref_o;
    hist[2] = hist[1];
    hist[1] = hist[0];
    for (int c = 0; c < NCH; c++) cmp_i[c] = pat(mode, c, cyc, lfsr);
    hist[0] = cmp_i;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    cyc++;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cycle_body();
    end
  endtask

  task automatic set_mode(int m);
    mode = m;
    win_in_mode = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    cmp_i = '0;
    #1;
    check(fb_o == '0, "R8 reset feedback", int'(fb_o), 0);
    check(data_o == '0, "R8 reset data", int'(data_o), 0);
    check(valid_o == 1'b0, "R8 reset valid", int'(valid_o), 0);
    check(ref_o == 1'b0, "R8 reset reference", int'(ref_o), 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    for (int k = 0; k < 3; k++) hist[k] = '0;
    for (int c = 0; c < NCH; c++) sums[c] = 0;
    samp_cnt = 0;
    exp_q.delete();
    exp_due = 0;
    ref_prev = 1'b0;
    ref_run = 0;
    win_in_mode = 0;
    cycle_body();
  endtask

  initial begin
    for (int k = 0; k < 3; k++) hist[k] = '0;
    for (int c = 0; c < NCH; c++) sums[c] = 0;
    set_mode(0);
    do_reset();
    run(6 * WIN);
    set_mode(1);
    run(6 * WIN);
    set_mode(2);
    run(14 * WIN + 5);
    set_mode(0);
    do_reset();
    run(5 * WIN);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule